// File: doc/BRIEF.md
# Indexed Dual-Socket Register Access Port

This block lets a host reach a 256-location internal register space through a four-byte I/O window, using only two live byte addresses. The host first writes an index byte at window offset 0; every later access at window offset 1 then reads or writes the internal register that the index names. The index byte carries a socket-select bit, so one index value picks one of two banks of 64 per-socket registers. The upper half of the index space has no registers behind it.

A plain register array stands in for each socket's registers. The index holds its value across any number of data accesses and never auto-increments. A parameter mask marks some register indices as reserved: they read as zero and ignore writes. Offsets 2 and 3 of the window are inert. Read data comes from combinational logic, so it is valid in the same cycle as the read strobe.

Top module: `idx_dual_bank_port`

## Requirements
- R1: After reset the index reads 0x00 (socket A, register 0) and every socket register reads 0x00.
- R2: A write at offset 0 loads index bits 6..0 from the write data. Bit 7 of the index is always 0, and a read at offset 0 returns the index.
- R3: A write at offset 1 stores the byte in the register that the index selects. A later read at offset 1 with the same index returns that byte.
- R4: Index bit 6 picks the bank (0 = socket A, 1 = socket B) and index bits 5..0 pick the register. The two banks hold separate values for the same register number.
- R5: A write at offset 2 or 3 changes neither the index nor any register, and a read there returns 0x00.
- R6: Register indices whose bit is set in RSV_MASK are reserved: a data read returns 0x00 and a data write is dropped. The default mask reserves indices 4, 62 and 63 in both banks.
- R7: Data accesses at offset 1 leave the index unchanged, so there is no auto-increment.
- R8: When chip select is low, both strobes are ignored, and read data is 0x00 whenever a read at a selected offset is not in progress.
- R9: Read data is valid in the same clock cycle as the read strobe, with no wait cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select for the window |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe, takes effect at the clock edge |
| ofs | input | 2 | Byte offset inside the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |

## Verification
On every cycle the assertions check several properties. The index high bit stays clear. The index holds unless an offset-0 write occurs. A bank array holds unless it has a write enable. At most one bank is enabled at a time, and reserved indices never produce a write enable. Read data is zero for idle cycles, for offsets 2 and 3 and for reserved indices. Only the bench's scenarios can show that a stored byte lands in the right bank and register and comes back later. They also show that the two sockets do not alias, and that a long run of data accesses leaves the index where it was.

// File: rtl/idxport_pkg.sv
// Package: shared types for the indexed dual-socket register port.
// Assumes a window of four byte offsets and exactly two socket banks.
package idxport_pkg;
    typedef enum logic [1:0] {
        OFS_INDEX  = 2'd0,
        OFS_DATA   = 2'd1,
        OFS_SPARE2 = 2'd2,
        OFS_SPARE3 = 2'd3
    } win_ofs_e;

    localparam int SOCKETS = 2;
endpackage

// File: rtl/idxport_index_reg.sv
// Index register: holds the register index and the socket-select bit.
// Assumes the caller passes only the low KEEP_W write bits; the upper bits are
// reserved and are held at zero.
module idxport_index_reg #(
    parameter int DATA_W    = 8,
    parameter int REG_IDX_W = 6,
    localparam int KEEP_W   = REG_IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [KEEP_W-1:0] wdata_i,
    output logic [DATA_W-1:0] index_o
);
    logic [DATA_W-1:0] index_q;

    // Load the kept index bits on an offset-0 write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
        end else if (load_i) begin
            index_q <= {{(DATA_W-KEEP_W){1'b0}}, wdata_i};
        end
    end

    assign index_o = index_q;

    AST_IDX_RSV_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        index_q[DATA_W-1:KEEP_W] == '0); // R2
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(index_q)); // R7
endmodule

// File: rtl/idxport_decode.sv
// Access decode: turns chip select, strobe and offset into an index load and
// per-socket data write enables, and flags reserved register indices.
// Assumes index_i carries the register index in its low bits and the socket
// bit just above it.
module idxport_decode
    import idxport_pkg::*;
#(
    parameter int REG_IDX_W = 6,
    localparam int NUM_REGS = 1 << REG_IDX_W,
    parameter logic [NUM_REGS-1:0] RSV_MASK = '0
) (
    input  logic                 cs_i,
    input  logic                 wr_i,
    input  logic [1:0]           ofs_i,
    input  logic [REG_IDX_W:0]   index_i,
    output logic                 idx_load_o,
    output logic [SOCKETS-1:0]   data_we_o,
    output logic [REG_IDX_W-1:0] reg_addr_o,
    output logic                 sock_o,
    output logic                 rsv_o
);
    win_ofs_e ofs_e;
    logic     data_wr;

    // Split the index and classify the offset of the current access.
    always_comb begin
        ofs_e      = win_ofs_e'(ofs_i);
        reg_addr_o = index_i[REG_IDX_W-1:0];
        sock_o     = index_i[REG_IDX_W];
        rsv_o      = RSV_MASK[reg_addr_o];
        idx_load_o = cs_i && wr_i && (ofs_e == OFS_INDEX);
        data_wr    = cs_i && wr_i && (ofs_e == OFS_DATA) && !rsv_o;
    end

    // One write enable per socket bank, qualified by the socket bit.
    for (genvar s = 0; s < SOCKETS; s++) begin : g_we
        assign data_we_o[s] = data_wr && (sock_o == 1'(s));
    end

    // Check the enables that the decode hands to the banks.
    always_comb begin
        AST_WE_ONEHOT0: assert ($onehot0(data_we_o)); // R4
        AST_RSV_NO_WE: assert (!rsv_o || data_we_o == '0); // R6
    end
endmodule

// File: rtl/idxport_bank.sv
// Socket register bank: a plain array of DEPTH bytes with one write port and
// one combinational read port at the same address.
// Assumes a write and a read in the same cycle use the same address.
module idxport_bank #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DEPTH-1:0][DATA_W-1:0] mem_q;

    // Store a byte on an enabled write; clear the whole bank on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[addr_i];

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(mem_q)); // R5 R6
endmodule

// File: rtl/idx_dual_bank_port.sv
// Top: indexed dual-socket register access port. Offset 0 is the index,
// offset 1 the data path to the selected socket register, offsets 2 and 3
// are inert. Read data is combinational.
// Assumes DATA_W leaves at least one reserved bit above the socket bit.
module idx_dual_bank_port
    import idxport_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int REG_IDX_W = 6,
    localparam int NUM_REGS = 1 << REG_IDX_W,
    parameter logic [NUM_REGS-1:0] RSV_MASK = 64'hC000_0000_0000_0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [1:0]        ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int KEEP_W = REG_IDX_W + 1;

    logic [DATA_W-1:0]              index_q;
    logic                           idx_load;
    logic [SOCKETS-1:0]             data_we;
    logic [REG_IDX_W-1:0]           reg_addr;
    logic                           sock;
    logic                           rsv;
    logic [SOCKETS-1:0][DATA_W-1:0] bank_rd;

    idxport_index_reg #(.DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W)) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (idx_load),
        .wdata_i (wdata[KEEP_W-1:0]),
        .index_o (index_q)
    );

    idxport_decode #(.REG_IDX_W(REG_IDX_W), .RSV_MASK(RSV_MASK)) u_decode (
        .cs_i       (cs),
        .wr_i       (wr),
        .ofs_i      (ofs),
        .index_i    (index_q[KEEP_W-1:0]),
        .idx_load_o (idx_load),
        .data_we_o  (data_we),
        .reg_addr_o (reg_addr),
        .sock_o     (sock),
        .rsv_o      (rsv)
    );

    // One register bank per socket, sharing the register address.
    for (genvar s = 0; s < SOCKETS; s++) begin : g_bank
        idxport_bank #(.DATA_W(DATA_W), .ADDR_W(REG_IDX_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (data_we[s]),
            .addr_i  (reg_addr),
            .wdata_i (wdata),
            .rdata_o (bank_rd[s])
        );
    end

    // Select read data by offset; zero when idle, inert or reserved.
    always_comb begin
        rdata = '0;
        if (cs && rd) begin
            case (win_ofs_e'(ofs))
                OFS_INDEX: rdata = index_q;
                OFS_DATA:  rdata = rsv ? '0 : bank_rd[sock];
                default:   rdata = '0;
            endcase
        end
    end

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd) |-> rdata == '0); // R8
    AST_SPARE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && ofs[1]) |-> rdata == '0); // R5
    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && ofs == 2'd1 && RSV_MASK[index_q[REG_IDX_W-1:0]]) |-> rdata == '0); // R6
    AST_NO_INDEX_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && ofs != 2'd0) |=> $stable(index_q)); // R7
endmodule

// File: tb/idx_dual_bank_port_tb.sv
`timescale 1ns/1ps
module idx_dual_bank_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] ofs = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    // Behavioural reference: flat 128-entry space, socket * 64 + register.
    logic [7:0] m_idx = 8'd0;
    logic [7:0] m_reg [0:127];

    always #4 clk = ~clk;

    idx_dual_bank_port dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr),
        .ofs(ofs), .wdata(wdata), .rdata(rdata)
    );

    function automatic bit is_rsv(input int r);
        return (r == 4) || (r >= 62);
    endfunction

    function automatic logic [7:0] model_rd(input logic c, input logic r, input logic [1:0] o);
        int loc;
        if (!(c && r)) return 8'h00;
        if (o == 2'd0) return m_idx;
        if (o == 2'd1) begin
            if (is_rsv(int'(m_idx[5:0]))) return 8'h00;
            loc = int'(m_idx[6]) * 64 + int'(m_idx[5:0]);
            return m_reg[loc];
        end
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rdata=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    // One bus cycle: drive at negedge, compare in the same cycle, update model at the edge.
    task automatic step(input logic c, input logic r, input logic w, input logic [1:0] o,
                        input logic [7:0] d, input string req);
        @(negedge clk);
        cs = c; rd = r; wr = w; ofs = o; wdata = d;
        #1;
        check(req, rdata, model_rd(c, r, o));
        @(posedge clk);
        if (c && w) begin
            if (o == 2'd0) m_idx = {1'b0, d[6:0]};
            else if (o == 2'd1 && !is_rsv(int'(m_idx[5:0])))
                m_reg[int'(m_idx[6]) * 64 + int'(m_idx[5:0])] = d;
        end
    endtask

    task automatic wr_b(input logic [1:0] o, input logic [7:0] d, input string req);
        step(1'b1, 1'b0, 1'b1, o, d, req);
    endtask

    task automatic rd_b(input logic [1:0] o, input string req);
        step(1'b1, 1'b1, 1'b0, o, 8'h00, req);
    endtask

    task automatic expect_rd(input logic [1:0] o, input logic [7:0] exp, input string req);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; wr = 1'b0; ofs = o; wdata = 8'h00;
        #1;
        check(req, rdata, exp);
        check(req, rdata, model_rd(1'b1, 1'b1, o));
        @(posedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: rdata=%02h expected=completion", rdata);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 128; i++) m_reg[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of index and registers
        expect_rd(2'd0, 8'h00, "R1");
        expect_rd(2'd1, 8'h00, "R1");

        // R3 / R9: store and read back in the same cycle as the strobe
        wr_b(2'd0, 8'h05, "R3");
        wr_b(2'd1, 8'hA5, "R3");
        expect_rd(2'd1, 8'hA5, "R9");

        // R4: socket B, same register number, is a separate location
        wr_b(2'd0, 8'h45, "R4");
        expect_rd(2'd1, 8'h00, "R4");
        wr_b(2'd1, 8'h5A, "R4");
        expect_rd(2'd1, 8'h5A, "R4");
        wr_b(2'd0, 8'h05, "R4");
        expect_rd(2'd1, 8'hA5, "R4");

        // R2: bit 7 is dropped on write and reads as 0
        wr_b(2'd0, 8'hC5, "R2");
        expect_rd(2'd0, 8'h45, "R2");
        expect_rd(2'd1, 8'h5A, "R2");

        // R6: reserved indices read zero and drop writes
        wr_b(2'd0, 8'hFF, "R6");
        expect_rd(2'd0, 8'h7F, "R6");
        wr_b(2'd1, 8'h11, "R6");
        expect_rd(2'd1, 8'h00, "R6");
        wr_b(2'd0, 8'h04, "R6");
        wr_b(2'd1, 8'h33, "R6");
        expect_rd(2'd1, 8'h00, "R6");
        wr_b(2'd0, 8'h03, "R6");
        expect_rd(2'd1, 8'h00, "R6");
        wr_b(2'd0, 8'h05, "R6");
        expect_rd(2'd1, 8'hA5, "R6");

        // R5: offsets 2 and 3 are inert
        wr_b(2'd2, 8'h99, "R5");
        wr_b(2'd3, 8'h77, "R5");
        expect_rd(2'd0, 8'h05, "R5");
        expect_rd(2'd1, 8'hA5, "R5");
        expect_rd(2'd2, 8'h00, "R5");
        expect_rd(2'd3, 8'h00, "R5");

        // R7: repeated data accesses leave the index in place
        rd_b(2'd1, "R7");
        rd_b(2'd1, "R7");
        wr_b(2'd1, 8'hA6, "R7");
        expect_rd(2'd0, 8'h05, "R7");
        expect_rd(2'd1, 8'hA6, "R7");

        // R8: strobes without chip select are ignored, idle reads are zero
        step(1'b0, 1'b1, 1'b0, 2'd0, 8'h00, "R8");
        step(1'b0, 1'b0, 1'b1, 2'd0, 8'h2A, "R8");
        step(1'b0, 1'b0, 1'b1, 2'd1, 8'hEE, "R8");
        step(1'b1, 1'b0, 1'b0, 2'd0, 8'h00, "R8");
        expect_rd(2'd0, 8'h05, "R8");
        expect_rd(2'd1, 8'hA6, "R8");

        // R3 / R4: sweep every register of both sockets, then read all back
        for (int s = 0; s < 2; s++) begin
            for (int r = 0; r < 64; r++) begin
                wr_b(2'd0, 8'(s * 64 + r), "R3");
                wr_b(2'd1, 8'((r * 7 + s * 91 + 3) & 8'hFF), "R3");
            end
        end
        for (int s = 0; s < 2; s++) begin
            for (int r = 0; r < 64; r++) begin
                wr_b(2'd0, 8'(s * 64 + r), "R4");
                rd_b(2'd1, "R4");
            end
        end

        // R1: a second reset clears index and registers
        @(negedge clk);
        cs = 1'b0; rd = 1'b0; wr = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_idx = 8'h00;
        for (int i = 0; i < 128; i++) m_reg[i] = 8'h00;
        expect_rd(2'd0, 8'h00, "R1");
        wr_b(2'd0, 8'h45, "R1");
        expect_rd(2'd1, 8'h00, "R1");

        finish_run();
    end
endmodule